// File: doc/BRIEF.md
# Codec Control Word Serializer

This block sends control words to an audio converter that can only be written over a three-wire serial link. The wires are an active-low select, a serial clock and a data line. A write strobe is held high for the whole of each transfer. A request carries a 7-bit register number and a value. The block packs these into a 16-bit word and shifts the word out most significant bit first. Every line change is held for a fixed number of system clock cycles, set by the parameter `UNIT`.

The converter's registers cannot be read back, so the block keeps its own copy of the lower register numbers. Each accepted request writes its value into that copy unless the request sets the bypass flag. The copy can be read at any time through a separate read port, without waiting for a transfer.

Each transfer ends with the clock falling in the same cycle that select rises. One further clock high phase then follows while select stays high. The request port is held not-ready until that trailing phase has finished.

Top module: `codec_wr_engine`

## Requirements
- R1: The transmitted word carries `req_addr` in bits 15..9 and the low 9 bits of `req_value` in bits 8..0. Bits 15..9 of `req_value` never appear on the line.
- R2: Each transfer has exactly 16 rising `ser_clk` edges while `ser_cs_n` is low. `ser_dat` at each rising edge carries the word, bit 15 first.
- R3: `ser_cs_n` falls in the cycle after acceptance, and `ser_wr` is high whenever `ser_cs_n` is low. The first fall of `ser_clk` comes exactly `UNIT` cycles after `ser_cs_n` falls.
- R4: Each bit is sent in three phases of `UNIT` cycles each: clock low, then data update, then clock high. Rising clock edges inside a transfer are therefore `3*UNIT` cycles apart, and `ser_dat` does not change in a cycle where the clock rises.
- R5: `ser_cs_n` rises in the same cycle as `ser_clk` falls after the last bit. `ser_clk` then rises once more, `UNIT` cycles later, while `ser_cs_n` is still high.
- R6: `req_ready` falls in the cycle after a request is accepted and stays low for exactly `51*UNIT` cycles. A request held valid while `req_ready` is low is not taken, so every held request produces exactly one transfer.
- R7: An accepted request with `req_nocache` low and `req_addr` below 32 stores the low 9 bits of `req_value` into shadow entry `req_addr[4:0]`. The stored value is visible on `rd_data` in the cycle after acceptance.
- R8: An accepted request with `req_nocache` high leaves every shadow entry unchanged but is still transmitted.
- R9: An accepted request with `req_addr` 32 or higher leaves every shadow entry unchanged but is still transmitted.
- R10: After reset, `ser_cs_n` and `ser_clk` are high, `ser_dat` and `ser_wr` are low, `req_ready` is high, and all 32 shadow entries read zero.
- R11: While the block is idle, `ser_cs_n` and `ser_clk` are high and `ser_dat` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_addr | input | 7 | Codec register number |
| req_value | input | 16 | Register value; only bits 8..0 are used |
| req_nocache | input | 1 | Bypass the shadow update for this request |
| rd_addr | input | 5 | Shadow entry to read |
| rd_data | output | 9 | Contents of the selected shadow entry |
| ser_cs_n | output | 1 | Active-low select to the codec |
| ser_clk | output | 1 | Serial clock; the codec samples on its rising edge |
| ser_dat | output | 1 | Serial data |
| ser_wr | output | 1 | Write strobe, high during a transfer |

## Verification
The hardest case to reach is a request that arrives while a transfer is still running. The driver raises the next request straight after the previous handshake and holds it valid through the entire busy window. The monitor then counts the completed transfers against the requests sent, which shows that no request was taken twice or lost. The same stimulus runs with a small `UNIT`, so that the phase timing of select, clock and data can be checked edge by edge.

// File: rtl/codec_wr_pkg.sv
package codec_wr_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_CLK_LO = 3'd2,
    PH_DAT    = 3'd3,
    PH_CLK_HI = 3'd4,
    PH_END    = 3'd5,
    PH_TAIL   = 3'd6
  } phase_e;
endpackage

// File: rtl/cwe_prescaler.sv
module cwe_prescaler #(
  parameter int UNIT = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (UNIT > 1) ? $clog2(UNIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(UNIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = en && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!en || tick) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cwe_sequencer.sv
module cwe_sequencer
  import codec_wr_pkg::*;
#(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               tick,
  output logic               busy,
  output logic               cs_n,
  output logic               sclk,
  output logic               sdat,
  output logic               wr
);
  localparam int BIT_W = $clog2(FRAME_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

  phase_e             state_q, state_d;
  logic [BIT_W-1:0]   bit_q, bit_d;
  logic [FRAME_W-1:0] sreg_q, sreg_d;
  logic               dat_q, dat_d;

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    sreg_d  = sreg_q;
    dat_d   = dat_q;
    case (state_q)
      PH_IDLE: begin
        if (start) begin
          sreg_d  = frame_i;
          bit_d   = '0;
          state_d = PH_SETUP;
        end
      end
      PH_SETUP:  if (tick) state_d = PH_CLK_LO;
      PH_CLK_LO: if (tick) begin
        dat_d   = sreg_q[FRAME_W-1];
        state_d = PH_DAT;
      end
      PH_DAT:    if (tick) state_d = PH_CLK_HI;
      PH_CLK_HI: if (tick) begin
        if (bit_q == LAST_BIT) begin
          state_d = PH_END;
        end else begin
          bit_d   = bit_q + 1'b1;
          sreg_d  = {sreg_q[FRAME_W-2:0], 1'b0};
          state_d = PH_CLK_LO;
        end
      end
      PH_END:    if (tick) state_d = PH_TAIL;
      PH_TAIL:   if (tick) begin
        dat_d   = 1'b0;
        state_d = PH_IDLE;
      end
      default:   state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      bit_q   <= '0;
      sreg_q  <= '0;
      dat_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      sreg_q  <= sreg_d;
      dat_q   <= dat_d;
    end
  end

  assign busy = (state_q != PH_IDLE);
  assign wr   = busy;
  assign cs_n = (state_q == PH_IDLE) || (state_q == PH_END) || (state_q == PH_TAIL);
  assign sclk = !((state_q == PH_CLK_LO) || (state_q == PH_DAT) || (state_q == PH_END));
  assign sdat = dat_q;
endmodule

// File: rtl/cwe_shadow.sv
module cwe_shadow #(
  parameter int DEPTH  = 32,
  parameter int DW     = 9,
  parameter int ADDR_W = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DW-1:0]            wr_data,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [DW-1:0]            rd_data
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic          in_range;

  assign in_range = ({1'b0, wr_addr} < LIMIT);

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic hit;
    assign hit = wr_en && in_range && (wr_addr[IDX_W-1:0] == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem_q[g] <= '0;
      else if (hit) mem_q[g] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/codec_wr_engine.sv
module codec_wr_engine #(
  parameter int ADDR_W = 7,
  parameter int VAL_W  = 9,
  parameter int IN_W   = 16,
  parameter int DEPTH  = 32,
  parameter int UNIT   = 200
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [IN_W-1:0]          req_value,
  input  logic                     req_nocache,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [VAL_W-1:0]         rd_data,
  output logic                     ser_cs_n,
  output logic                     ser_clk,
  output logic                     ser_dat,
  output logic                     ser_wr
);
  localparam int FRAME_W = ADDR_W + VAL_W;

  logic busy, tick, start;
  logic [FRAME_W-1:0] frame;
  logic unused_hi;

  assign start     = req_valid && !busy;
  assign req_ready = !busy;
  assign frame     = {req_addr, req_value[VAL_W-1:0]};
  assign unused_hi = ^req_value[IN_W-1:VAL_W];

  cwe_prescaler #(.UNIT(UNIT)) i_presc (
    .clk(clk), .rst_n(rst_n), .en(busy), .tick(tick)
  );

  cwe_sequencer #(.FRAME_W(FRAME_W)) i_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_i(frame), .tick(tick),
    .busy(busy), .cs_n(ser_cs_n), .sclk(ser_clk), .sdat(ser_dat), .wr(ser_wr)
  );

  cwe_shadow #(.DEPTH(DEPTH), .DW(VAL_W), .ADDR_W(ADDR_W)) i_shadow (
    .clk(clk), .rst_n(rst_n), .wr_en(start && !req_nocache),
    .wr_addr(req_addr), .wr_data(req_value[VAL_W-1:0]),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: rtl/codec_wr_checker.sv
module codec_wr_checker #(
  parameter int ADDR_W = 7,
  parameter int VAL_W  = 9,
  parameter int IN_W   = 16,
  parameter int DEPTH  = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic [ADDR_W-1:0]        req_addr,
  input logic [IN_W-1:0]          req_value,
  input logic                     req_nocache,
  input logic [$clog2(DEPTH)-1:0] rd_addr,
  input logic [VAL_W-1:0]         rd_data,
  input logic                     ser_cs_n,
  input logic                     ser_clk,
  input logic                     ser_dat,
  input logic                     ser_wr
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(DEPTH);

  logic acc;
  assign acc = req_valid && req_ready;

  // R3
  wr_during_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_cs_n |-> ser_wr);

  // R4
  data_steady_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ser_clk) && !ser_cs_n) |-> $stable(ser_dat));

  // R5
  select_release_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_cs_n) |-> !ser_clk);

  // R6
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !req_ready);

  // R11
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ser_cs_n && ser_clk && !ser_dat && !ser_wr));

  // R7
  shadow_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_nocache && ({1'b0, req_addr} < LIMIT) &&
     (req_addr[IDX_W-1:0] == rd_addr))
    |=> (!$stable(rd_addr) || rd_data == $past(req_value[VAL_W-1:0])));

  // R8
  shadow_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_nocache) |=> (!$stable(rd_addr) || $stable(rd_data)));
endmodule

bind codec_wr_engine codec_wr_checker #(
  .ADDR_W(ADDR_W), .VAL_W(VAL_W), .IN_W(IN_W), .DEPTH(DEPTH)
) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_value(req_value), .req_nocache(req_nocache),
  .rd_addr(rd_addr), .rd_data(rd_data), .ser_cs_n(ser_cs_n),
  .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_wr(ser_wr)
);

// File: tb/test_codec_wr_engine.sv
module test_codec_wr_engine;
  localparam int UNIT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [6:0]  req_addr = '0;
  logic [15:0] req_value = '0;
  logic        req_nocache = 1'b0;
  logic [4:0]  rd_addr = '0;
  logic [8:0]  rd_data;
  logic        ser_cs_n, ser_clk, ser_dat, ser_wr;

  always #2.5 clk = ~clk;

  codec_wr_engine #(.UNIT(UNIT)) i_codec_wr_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_value(req_value), .req_nocache(req_nocache),
    .rd_addr(rd_addr), .rd_data(rd_data), .ser_cs_n(ser_cs_n),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_wr(ser_wr)
  );

  int checks = 0;
  int errors = 0;
  int sent = 0;
  int frames = 0;
  bit finished = 0;
  logic [15:0] exp_q[$];
  logic [8:0]  model[32];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Driver: push expected frame, hold valid until the handshake edge
  task automatic send(input logic [6:0] a, input logic [15:0] v, input bit nc);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_value = v; req_nocache = nc;
    while (!req_ready) @(negedge clk);
    exp_q.push_back({a, v[8:0]});
    if (!nc && a < 7'd32) model[a[4:0]] = v[8:0];
    sent++;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready || ser_wr) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_shadow(input logic [4:0] idx, input string req);
    @(negedge clk);
    rd_addr = idx;
    #1;
    chk(rd_data == model[idx], req, int'(rd_data), int'(model[idx]));
  endtask

  // Monitor
  int cyc = 0;
  int cs_fall_t, cs_rise_t, last_rise, rdy_fall_t, nbits;
  bit first_fall_pend = 0, tail_pend = 0;
  logic prev_cs = 1'b1, prev_clk = 1'b1, prev_rdy = 1'b1;
  logic [15:0] cap;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (prev_cs && !ser_cs_n) begin
        chk(ser_wr == 1'b1, "R3 strobe high at select fall", int'(ser_wr), 1);
        cs_fall_t = cyc; nbits = 0; cap = '0; first_fall_pend = 1;
      end
      if (!ser_cs_n && prev_clk && !ser_clk && first_fall_pend) begin
        chk(cyc - cs_fall_t == UNIT, "R3 select to first clock fall", cyc - cs_fall_t, UNIT);
        first_fall_pend = 0;
      end
      if (!ser_cs_n && !prev_clk && ser_clk) begin
        if (nbits > 0)
          chk(cyc - last_rise == 3*UNIT, "R4 bit period", cyc - last_rise, 3*UNIT);
        last_rise = cyc;
        cap = {cap[14:0], ser_dat};
        nbits++;
      end
      if (!prev_cs && ser_cs_n) begin
        chk(ser_clk == 1'b0, "R5 clock low at select release", int'(ser_clk), 0);
        chk(nbits == 16, "R2 bits per word", nbits, 16);
        if (exp_q.size() == 0) chk(0, "R1 unexpected word", int'(cap), 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(cap == e, "R1 R2 word contents", int'(cap), int'(e));
        end
        tail_pend = 1; cs_rise_t = cyc;
      end
      if (ser_cs_n && !prev_clk && ser_clk && tail_pend) begin
        chk(cyc - cs_rise_t == UNIT, "R5 trailing clock phase", cyc - cs_rise_t, UNIT);
        tail_pend = 0;
        frames++;
      end
      if (prev_rdy && !req_ready) rdy_fall_t = cyc;
      if (!prev_rdy && req_ready)
        chk(cyc - rdy_fall_t == 51*UNIT, "R6 busy window", cyc - rdy_fall_t, 51*UNIT);
      prev_cs = ser_cs_n; prev_clk = ser_clk; prev_rdy = req_ready;
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(ser_cs_n == 1'b1, "R10 select idle high", int'(ser_cs_n), 1);
    chk(ser_clk == 1'b1, "R10 clock idle high", int'(ser_clk), 1);
    chk(ser_dat == 1'b0, "R10 data low", int'(ser_dat), 0);
    chk(ser_wr == 1'b0, "R10 strobe low", int'(ser_wr), 0);
    chk(req_ready == 1'b1, "R10 ready high", int'(req_ready), 1);
    rst_n = 1'b1;
    for (int i = 0; i < 32; i++) check_shadow(5'(i), "R10 shadow cleared");

    // R7: normal write
    send(7'h05, 16'h01AB, 0);
    wait_idle();
    check_shadow(5'h05, "R7 shadow stored");
    // R9: address beyond shadow, entry 31 untouched
    send(7'h7F, 16'h0000, 0);
    send(7'h3F, 16'h0123, 0);
    wait_idle();
    check_shadow(5'h1F, "R9 high address ignored by shadow");
    // R1: upper value bits discarded
    send(7'h1F, 16'hFFFF, 0);
    wait_idle();
    check_shadow(5'h1F, "R1 R7 low nine bits stored");
    // R8: bypass keeps the old value
    send(7'h05, 16'h00AA, 1);
    wait_idle();
    check_shadow(5'h05, "R8 bypass leaves shadow");
    // R6: back-to-back requests held valid during busy
    send(7'h0A, 16'h0155, 0);
    send(7'h00, 16'h0080, 0);
    send(7'h55, 16'hFE2A, 0);
    wait_idle();
    check_shadow(5'h0A, "R7 shadow stored");
    check_shadow(5'h00, "R7 shadow stored");
    chk(frames == sent, "R6 one word per request", frames, sent);
    chk(exp_q.size() == 0, "R6 no word missing", exp_q.size(), 0);
    // R11: idle lines
    chk(ser_cs_n && ser_clk && !ser_dat, "R11 idle lines",
        int'({ser_cs_n, ser_clk, ser_dat}), 6);
    finish_up();
  end
endmodule